// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programmable start address and transfer count of each channel of a small four-channel DMA controller, and tracks how far each channel has progressed. Software reaches the registers through an 8-bit port: every register is 16 bits wide, so it is reached with two accesses. A single pointer bit, shared by all channels, selects the low or the high byte. It flips after each access, so a pair of accesses always covers low then high.

Writing the high byte of either register of a channel restarts that channel. Its working address is reloaded from the programmed start and its progress counter is cleared. The transfer engine pulses a per-channel strobe for each unit moved. Reads return live values: the address the channel has reached, and the count still left. A parameter selects word mode. In word mode the port offset ignores the lowest port-address bit, addresses and counts are in two-byte units, and the transfer length doubles.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the byte pointer is 0, and all programmed addresses, programmed counts, working addresses and progress counters are 0, so every register reads 0x00 and every `xfer_done` bit is low.
- R2: The port offset is `port_addr` (byte mode) or `port_addr[3:1]` (word mode, bit 0 ignored); offset bits [2:1] pick the channel and offset bit 0 picks the address register (0) or the count register (1).
- R3: The byte pointer flips on every cycle with `wr_en` or `rd_en` high and holds otherwise; pointer 0 accesses the low byte, pointer 1 the high byte.
- R4: A low-byte write replaces only bits [7:0] of the selected register, a high-byte write only bits [15:8]; a low-byte write does not restart the channel.
- R5: A high-byte write to either register of a channel loads its working address with the programmed address shifted left by the width shift (0 byte mode, 1 word mode), and clears its progress counter.
- R6: An address read returns the working address plus the progress counter when the channel's `chan_dec` bit is 0, and minus it when 1, modulo the register width.
- R7: A count read returns the programmed count shifted left by the width shift, minus the progress counter; after a completed transfer it reads 0xFFFF.
- R8: Each `xfer_stb` pulse adds 1 shifted left by the width shift to that channel's progress counter, which saturates at (programmed count + 1) shifted left by the width shift; `xfer_done` is high while the counter is at that length.
- R9: In word mode the returned byte is the read value shifted right by 1, plus 8 when the pointer is 1.
- R10: A write to one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | 3 (4 in word mode) | Register port address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read, combinational from current state |
| chan_dec | input | 4 | Per-channel decrement-address selection |
| xfer_stb | input | 4 | Per-channel one-unit-transferred strobe |
| xfer_done | output | 4 | Per-channel transfer length reached |

## Verification
The assertions watch, on every cycle, the pointer flipping on accesses and holding when idle, the restart that clears progress after a high-byte write, and the progress counter's step and its saturation. Byte ordering across access pairs, the arithmetic of the live address in both directions, the count read reaching 0xFFFF, channel isolation and the word-mode port decode and byte shift need whole access sequences. Only the bench scenarios show these, checked against values worked out by hand.

// File: rtl/dma_regs_pkg.sv
// Package: shared constants and types for the DMA channel register file.
// Assumes registers are 16 bits and the data port is one byte wide.
package dma_regs_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_CNT  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: shared low/high byte pointer. Flips on every register access.
// Assumes at most one access per cycle; simultaneous read and write count once.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic hi_sel
);
    // Flip the pointer on each access, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_sel <= 1'b0;
        else if (access) hi_sel <= ~hi_sel;
    end

    assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> (hi_sel != $past(hi_sel)));
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(hi_sel));
endmodule

// File: rtl/dma_chan_slot.sv
// Module: one channel's programmed address/count, working address and
// progress counter. Assumes wr_en is already qualified for this channel.
module dma_chan_slot
    import dma_regs_pkg::*;
#(
    parameter int SHIFT = 0,
    parameter int VW    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_reg,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              stb,
    output logic [REG_W-1:0]  base_cnt,
    output logic [VW-1:0]     cur_addr,
    output logic [VW-1:0]     xfer,
    output logic              done
);
    localparam logic [VW-1:0] STEP = VW'(1) << SHIFT;

    logic [REG_W-1:0] base_addr;
    logic [REG_W-1:0] addr_next, cnt_next;
    logic [VW-1:0]    xfer_len, xfer_inc;
    logic             restart;

    // Merge the written byte into the addressed half of each register.
    always_comb begin
        addr_next = base_addr;
        cnt_next  = base_cnt;
        if (wr_en && wr_reg == SEL_ADDR)
            addr_next = wr_hi ? {wr_data, base_addr[7:0]} : {base_addr[15:8], wr_data};
        if (wr_en && wr_reg == SEL_CNT)
            cnt_next = wr_hi ? {wr_data, base_cnt[7:0]} : {base_cnt[15:8], wr_data};
        restart  = wr_en && wr_hi;
        xfer_len = (VW'(base_cnt) + VW'(1)) << SHIFT;
        xfer_inc = xfer + STEP;
        done     = (xfer >= xfer_len);
    end

    // Hold the programmed address and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            base_addr <= addr_next;
            base_cnt  <= cnt_next;
        end
    end

    // Reload the working address on a channel restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_addr <= '0;
        else if (restart) cur_addr <= VW'(addr_next) << SHIFT;
    end

    // Count transferred units, saturating at the transfer length.
    always_ff @(posedge clk) begin
        if (!rst_n)             xfer <= '0;
        else if (restart)       xfer <= '0;
        else if (stb && !done)  xfer <= (xfer_inc >= xfer_len) ? xfer_len : xfer_inc;
    end

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (xfer == '0));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_en && wr_hi)) |=> $stable(xfer));
    assert_step_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !done && !(wr_en && wr_hi)) |=> (xfer > $past(xfer)));
endmodule

// File: rtl/dma_read_mux.sv
// Module: forms the live address or remaining count of the selected channel
// and picks the byte the pointer asks for. Purely combinational.
module dma_read_mux
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int SHIFT  = 0,
    parameter int VW     = 17
) (
    input  logic [CH_W-1:0]             ch,
    input  reg_sel_e                    rsel,
    input  logic                        hi_sel,
    input  logic [NUM_CH-1:0]           dec,
    input  logic [NUM_CH-1:0][VW-1:0]   cur_addr,
    input  logic [NUM_CH-1:0][VW-1:0]   xfer,
    input  logic [NUM_CH-1:0][REG_W-1:0] base_cnt,
    output logic [BYTE_W-1:0]           rd_data
);
    logic [VW-1:0] val, shifted;

    // Live value, then drop the width shift and pick low or high byte.
    always_comb begin
        if (rsel == SEL_CNT)  val = (VW'(base_cnt[ch]) << SHIFT) - xfer[ch];
        else if (dec[ch])     val = cur_addr[ch] - xfer[ch];
        else                  val = cur_addr[ch] + xfer[ch];
        shifted = hi_sel ? (val >> (SHIFT + 8)) : (val >> SHIFT);
        rd_data = shifted[BYTE_W-1:0];
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of the DMA channel register file. Decodes the port offset,
// steers writes to the addressed channel and returns live read bytes.
// Assumes the caller never raises wr_en and rd_en in the same cycle.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter bit WORD_MODE = 1'b0,
    localparam int SHIFT    = WORD_MODE ? 1 : 0,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int PW       = CH_W + 1 + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     port_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [NUM_CH-1:0] chan_dec,
    input  logic [NUM_CH-1:0] xfer_stb,
    output logic [NUM_CH-1:0] xfer_done
);
    localparam int VW = REG_W + 1 + SHIFT;

    logic [CH_W:0]                ofs;
    logic [CH_W-1:0]              ch;
    reg_sel_e                     rsel;
    logic                         hi_sel;
    logic [NUM_CH-1:0][VW-1:0]    cur_addr, xfer;
    logic [NUM_CH-1:0][REG_W-1:0] base_cnt;

    // Split the port offset into channel number and register select.
    always_comb begin
        ofs  = port_addr[PW-1:SHIFT];
        ch   = ofs[CH_W:1];
        rsel = reg_sel_e'(ofs[0]);
    end

    generate
        if (SHIFT != 0) begin : g_word
            logic unused_port_lsb;
            assign unused_port_lsb = port_addr[0];
        end
    endgenerate

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (wr_en | rd_en),
        .hi_sel (hi_sel)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            dma_chan_slot #(.SHIFT(SHIFT), .VW(VW)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en && (ch == CH_W'(i))),
                .wr_reg   (rsel),
                .wr_hi    (hi_sel),
                .wr_data  (wr_data),
                .stb      (xfer_stb[i]),
                .base_cnt (base_cnt[i]),
                .cur_addr (cur_addr[i]),
                .xfer     (xfer[i]),
                .done     (xfer_done[i])
            );
        end
    endgenerate

    dma_read_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SHIFT(SHIFT), .VW(VW)) u_rd (
        .ch       (ch),
        .rsel     (rsel),
        .hi_sel   (hi_sel),
        .dec      (chan_dec),
        .cur_addr (cur_addr),
        .xfer     (xfer),
        .base_cnt (base_cnt),
        .rd_data  (rd_data)
    );

    // Writes land only on the addressed channel (R10).
    assert_write_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ch != CH_W'(0)) |=> $stable(cur_addr[0]));
endmodule

// File: tb/dma_chan_regs_bench.sv
// Bench: vector table on a byte-mode instance, then directed tests for
// reset, decrement, restart, pointer hold and word mode.
module dma_chan_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // byte-mode instance signals
    logic [2:0] b_port = '0;
    logic       b_wr = 1'b0, b_rd = 1'b0;
    logic [7:0] b_wdat = '0, b_rdat;
    logic [3:0] b_dec = '0, b_stb = '0, b_done;
    // word-mode instance signals
    logic [3:0] w_port = '0;
    logic       w_wr = 1'b0, w_rd = 1'b0;
    logic [7:0] w_wdat = '0, w_rdat;
    logic [3:0] w_dec = '0, w_stb = '0, w_done;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .port_addr(b_port), .wr_en(b_wr), .rd_en(b_rd),
        .wr_data(b_wdat), .rd_data(b_rdat), .chan_dec(b_dec), .xfer_stb(b_stb),
        .xfer_done(b_done));

    dma_chan_regs #(.WORD_MODE(1'b1)) u_dma_chan_regs_w (
        .clk(clk), .rst_n(rst_n), .port_addr(w_port), .wr_en(w_wr), .rd_en(w_rd),
        .wr_data(w_wdat), .rd_data(w_rdat), .chan_dec(w_dec), .xfer_stb(w_stb),
        .xfer_done(w_done));

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // op: 0 write, 1 read, 2 strobe (data = channel mask)
    localparam int NV = 19;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 4'd2, 8'h34, 8'h00},  // R4 addr lo ch1
        {2'd0, 4'd2, 8'h12, 8'h00},  // R4 R5 addr hi ch1
        {2'd0, 4'd3, 8'h03, 8'h00},  // count lo ch1
        {2'd0, 4'd3, 8'h00, 8'h00},  // count hi ch1
        {2'd1, 4'd2, 8'h00, 8'h34},  // R6 live address lo
        {2'd1, 4'd2, 8'h00, 8'h12},  // R3 R6 hi byte next
        {2'd2, 4'd0, 8'h02, 8'h00},  // R8 step
        {2'd2, 4'd0, 8'h02, 8'h00},
        {2'd1, 4'd2, 8'h00, 8'h36},  // R6 0x1234+2
        {2'd1, 4'd2, 8'h00, 8'h12},
        {2'd1, 4'd3, 8'h00, 8'h01},  // R7 3-2
        {2'd1, 4'd3, 8'h00, 8'h00},
        {2'd2, 4'd0, 8'h02, 8'h00},
        {2'd2, 4'd0, 8'h02, 8'h00},
        {2'd2, 4'd0, 8'h02, 8'h00},  // R8 saturates at 4
        {2'd1, 4'd3, 8'h00, 8'hFF},  // R7 3-4 = 0xFFFF
        {2'd1, 4'd3, 8'h00, 8'hFF},
        {2'd1, 4'd4, 8'h00, 8'h00},  // R10 ch2 untouched
        {2'd1, 4'd4, 8'h00, 8'h00}
    };

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input bit w, input logic [3:0] port, input logic [7:0] d);
        @(negedge clk);
        if (w) begin w_port = port; w_wdat = d; w_wr = 1'b1; end
        else begin b_port = port[2:0]; b_wdat = d; b_wr = 1'b1; end
        @(negedge clk);
        b_wr = 1'b0; w_wr = 1'b0;
    endtask

    task automatic do_rd(input bit w, input logic [3:0] port, input logic [7:0] exp,
                         input string tag);
        @(negedge clk);
        if (w) begin w_port = port; w_rd = 1'b1; end
        else begin b_port = port[2:0]; b_rd = 1'b1; end
        #2;
        check(w ? w_rdat : b_rdat, exp, tag);
        @(negedge clk);
        b_rd = 1'b0; w_rd = 1'b0;
    endtask

    task automatic do_stb(input bit w, input logic [3:0] mask);
        @(negedge clk);
        if (w) w_stb = mask; else b_stb = mask;
        @(negedge clk);
        b_stb = '0; w_stb = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check({4'h0, b_done}, 8'h00, "R1 done after reset");
        check({4'h0, w_done}, 8'h00, "R1 word done after reset");
        do_rd(0, 4'd0, 8'h00, "R1 addr lo");
        do_rd(0, 4'd0, 8'h00, "R1 addr hi");
        do_rd(0, 4'd1, 8'h00, "R1 count lo");
        do_rd(0, 4'd1, 8'h00, "R1 count hi");

        // table walk: R2 R3 R4 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][21:20])
                2'd0: do_wr(0, VEC[i][19:16], VEC[i][15:8]);
                2'd1: do_rd(0, VEC[i][19:16], VEC[i][7:0], $sformatf("R6/R7 step %0d", i));
                default: do_stb(0, VEC[i][11:8]);
            endcase
        end
        check({4'h0, b_done}, 8'h02, "R8 done at length");

        // R6 decrement: 0x1234 - 4
        b_dec = 4'b0010;
        do_rd(0, 4'd2, 8'h30, "R6 dec lo");
        do_rd(0, 4'd2, 8'h12, "R6 dec hi");
        // R4: low write does not restart
        do_wr(0, 4'd2, 8'hFE);
        check({4'h0, b_done}, 8'h02, "R4 low write no restart");
        do_wr(0, 4'd2, 8'h00);
        check({4'h0, b_done}, 8'h00, "R5 restart clears done");
        do_rd(0, 4'd3, 8'h03, "R5 count after restart lo");
        do_rd(0, 4'd3, 8'h00, "R5 count after restart hi");
        do_rd(0, 4'd2, 8'hFE, "R5 addr reload lo");
        do_rd(0, 4'd2, 8'h00, "R5 addr reload hi");
        do_stb(0, 4'b0010);
        do_rd(0, 4'd2, 8'hFD, "R6 dec after step");
        // R3 pointer holds across idle cycles
        repeat (3) @(negedge clk);
        do_rd(0, 4'd2, 8'h00, "R3 hold then hi byte");
        do_rd(0, 4'd0, 8'h00, "R10 ch0 addr untouched");
        do_rd(0, 4'd0, 8'h00, "R10 ch0 addr hi");

        // word mode: R2 R9
        do_wr(1, 4'd0, 8'h00);
        do_wr(1, 4'd1, 8'h80);        // bit0 ignored: still address hi (R2)
        do_wr(1, 4'd2, 8'h01);
        do_wr(1, 4'd3, 8'h00);        // count = 1, length 4
        do_rd(1, 4'd0, 8'h00, "R9 word addr lo");
        do_rd(1, 4'd0, 8'h80, "R9 word addr hi");
        do_rd(1, 4'd2, 8'h01, "R9 word count lo");
        do_rd(1, 4'd2, 8'h00, "R9 word count hi");
        do_stb(1, 4'b0001);
        do_rd(1, 4'd1, 8'h01, "R2 R9 word addr after step");
        do_rd(1, 4'd1, 8'h80, "R9 word addr hi after step");
        do_rd(1, 4'd2, 8'h00, "R8 word count after step");
        do_rd(1, 4'd2, 8'h00, "R8 word count hi");
        do_stb(1, 4'b0001);
        do_stb(1, 4'b0001);
        check({4'h0, w_done}, 8'h01, "R8 word done");
        do_rd(1, 4'd2, 8'hFF, "R7 word count past end lo");
        do_rd(1, 4'd2, 8'hFF, "R7 word count past end hi");

        summary();
    end
endmodule